// File: doc/BRIEF.md
# Prescaled One-Shot Timer with Interrupt Combiner

This block counts CPU cycles down to a single expiry event and merges that event with a DMA-completion event into one level interrupt. Software starts the timer by writing an 8-bit count to the count register. The timer then counts only the clock cycles in which the CPU clock enable is high. A control bit, sampled at the moment of the load, sets the prescale to a short or a long step. At expiry the timer raises a sticky flag and stops. It does not run again until the count register is written once more.

A second sticky flag records a one-cycle pulse on the DMA-done input. Each flag has an enable bit in the control register. The enabled flags are ORed together and registered to drive the `irq` pin. Software reads both flags from a status offset. A read of either of two acknowledge offsets clears one flag. The register bus is a plain single-cycle select/write-enable interface: an access completes in the cycle it is presented, with no wait states and no back-pressure. Read data is valid in the same cycle as the read select and is zero when no read is presented.

Top module: `oneshot_irq_timer`

## Requirements
- R1: A write to offset 0x23 loads the written byte as the count and starts the timer. A written value of 0 counts as 256.
- R2: The timer expires after count × 2^FAST_LOG2 enabled cycles when control bit 4 is 0, and after count × 2^SLOW_LOG2 enabled cycles when it is 1. The defaults are 256 and 16384. The bit is sampled at the load, and cycles with `cpu_ce` low are not counted.
- R3: Expiry sets the timer flag, which stays set until acknowledged. The timer then stops and never expires again without a new load.
- R4: A one-cycle `dma_done` pulse sets the DMA flag, which stays set until acknowledged. A set and an acknowledge in the same cycle leave the flag set. The same rule applies to the timer flag.
- R5: A read of offset 0x27 returns the timer flag in bit 0 and the DMA flag in bit 1, with the other bits 0. A read of offset 0x26 returns the control register. Any other read returns 0.
- R6: `irq` is a register that holds (timer flag AND control bit 1) OR (DMA flag AND control bit 2), taken from the previous cycle.
- R7: A read of offset 0x24 clears the timer flag, and a read of offset 0x25 clears the DMA flag. `irq` falls on the cycle after the last enabled flag clears.
- R8: Reset clears both flags and the control register, stops the timer and drives `irq` low.
- R9: A write to offset 0x23 while the timer runs restarts it with the new count and the current prescale bit. A load in the cycle that would have expired cancels that expiry.
- R10: A write to the control register alone changes `irq` on the next cycle, using the flags already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU cycle enable; the timer counts only when high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as the read strobe |
| dma_done | input | 1 | One-cycle DMA completion pulse |
| irq | output | 1 | Level interrupt request |

## Verification
The bench aims at the cycle of expiry. It reads the status one cycle before and one cycle at the expected count for the short prescale, the long prescale and the zero-means-256 count. A design that is off by one in the prescaler, or that treats 0 as an empty count, shows the flag in the wrong read. It also restarts a running timer and later waits a long time after an acknowledge. A timer that kept its old period, or that reloaded itself, would raise the flag at the wrong moment or raise it a second time. The bench presents a DMA pulse together with its acknowledge, where an acknowledge-wins flag would be lost. It also turns an interrupt enable on over an already-set flag, where a design that updates `irq` only on flag events would stay silent. A behavioural model runs alongside throughout, with a gated `cpu_ce`, and compares `irq` and read data every cycle.

// File: rtl/ost_pkg.sv
`timescale 1ns/1ps
package ost_pkg;
  localparam int REG_W = 8;

  // register offsets (software-visible)
  localparam logic [7:0] OFS_COUNT = 8'h23;
  localparam logic [7:0] OFS_ACK_T = 8'h24;
  localparam logic [7:0] OFS_ACK_D = 8'h25;
  localparam logic [7:0] OFS_CTRL  = 8'h26;
  localparam logic [7:0] OFS_STAT  = 8'h27;

  // control register bit positions
  localparam int CTL_TIMER_EN = 1;
  localparam int CTL_DMA_EN   = 2;
  localparam int CTL_SLOW     = 4;

  // interrupt source indices
  localparam int SRC_TIMER = 0;
  localparam int SRC_DMA   = 1;
  localparam int NSRC      = 2;

  typedef struct packed {
    logic             load;
    logic [REG_W-1:0] load_val;
    logic             ack_timer;
    logic             ack_dma;
  } bus_evt_t;
endpackage

// File: rtl/ost_regbank.sv
`timescale 1ns/1ps
module ost_regbank
  import ost_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  input  logic [NSRC-1:0]   flags,
  output logic [REG_W-1:0]  bus_rdata,
  output logic [REG_W-1:0]  ctl,
  output bus_evt_t          evt
);
  localparam logic [ADDR_W-1:0] A_COUNT = OFS_COUNT[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ACK_T = OFS_ACK_T[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_ACK_D = OFS_ACK_D[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_CTRL  = OFS_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_STAT  = OFS_STAT[ADDR_W-1:0];

  logic wr_access;
  logic rd_access;

  assign wr_access = bus_sel &  bus_we;
  assign rd_access = bus_sel & ~bus_we;

  // control register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl <= '0;
    end else if (wr_access && bus_addr == A_CTRL) begin
      ctl <= bus_wdata;
    end
  end

  // one-cycle events towards timer and flag logic
  always_comb begin
    evt           = '0;
    evt.load      = wr_access && (bus_addr == A_COUNT);
    evt.load_val  = bus_wdata;
    evt.ack_timer = rd_access && (bus_addr == A_ACK_T);
    evt.ack_dma   = rd_access && (bus_addr == A_ACK_D);
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_access) begin
      if (bus_addr == A_STAT) begin
        bus_rdata[SRC_TIMER] = flags[SRC_TIMER];
        bus_rdata[SRC_DMA]   = flags[SRC_DMA];
      end else if (bus_addr == A_CTRL) begin
        bus_rdata = ctl;
      end
    end
  end
endmodule

// File: rtl/ost_countdown.sv
`timescale 1ns/1ps
module ost_countdown
  import ost_pkg::*;
#(
  parameter int FAST_LOG2 = 8,
  parameter int SLOW_LOG2 = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             load,
  input  logic [REG_W-1:0] load_val,
  input  logic             slow_sel,
  output logic             running,
  output logic             expire
);
  localparam int MAX_LOG2 = (SLOW_LOG2 > FAST_LOG2) ? SLOW_LOG2 : FAST_LOG2;
  localparam int PRE_W    = (MAX_LOG2 > 0) ? MAX_LOG2 : 1;
  localparam int MAIN_W   = REG_W + 1;
  localparam logic [PRE_W-1:0]  FAST_LAST = PRE_W'((64'd1 << FAST_LOG2) - 64'd1);
  localparam logic [PRE_W-1:0]  SLOW_LAST = PRE_W'((64'd1 << SLOW_LOG2) - 64'd1);
  localparam logic [MAIN_W-1:0] MAIN_ONE  = MAIN_W'(1);
  localparam logic [MAIN_W-1:0] MAIN_FULL = MAIN_W'(1) << REG_W;

  logic [PRE_W-1:0]  pre_q;
  logic [MAIN_W-1:0] main_q;
  logic              slow_q;
  logic              pre_wrap;
  logic              last_step;

  assign pre_wrap  = (pre_q == (slow_q ? SLOW_LAST : FAST_LAST));
  assign last_step = (main_q == MAIN_ONE);
  assign expire    = running & ce & ~load & pre_wrap & last_step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre_q   <= '0;
      main_q  <= '0;
      slow_q  <= 1'b0;
    end else if (load) begin
      running <= 1'b1;
      pre_q   <= '0;
      main_q  <= (load_val == '0) ? MAIN_FULL : {1'b0, load_val};
      slow_q  <= slow_sel;
    end else if (running && ce) begin
      if (pre_wrap) begin
        pre_q <= '0;
        if (last_step) begin
          running <= 1'b0;
        end else begin
          main_q <= main_q - MAIN_ONE;
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/ost_irq_combine.sv
`timescale 1ns/1ps
module ost_irq_combine
  import ost_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set,
  input  logic [NSRC-1:0] clr,
  input  logic [NSRC-1:0] en,
  output logic [NSRC-1:0] flags,
  output logic            irq
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
      end else if (set[i]) begin
        flags[i] <= 1'b1;
      end else if (clr[i]) begin
        flags[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
    end else begin
      irq <= |(flags & en);
    end
  end
endmodule

// File: rtl/oneshot_irq_timer.sv
`timescale 1ns/1ps
module oneshot_irq_timer
  import ost_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int FAST_LOG2 = 8,
  parameter int SLOW_LOG2 = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_ce,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              dma_done,
  output logic              irq
);
  logic [REG_W-1:0] ctl;
  bus_evt_t         evt;
  logic [NSRC-1:0]  flags;
  logic [NSRC-1:0]  set_v;
  logic [NSRC-1:0]  clr_v;
  logic [NSRC-1:0]  en_v;
  logic             running;
  logic             expire;

  ost_regbank #(.ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .flags     (flags),
    .bus_rdata (bus_rdata),
    .ctl       (ctl),
    .evt       (evt)
  );

  ost_countdown #(.FAST_LOG2(FAST_LOG2), .SLOW_LOG2(SLOW_LOG2)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ce       (cpu_ce),
    .load     (evt.load),
    .load_val (evt.load_val),
    .slow_sel (ctl[CTL_SLOW]),
    .running  (running),
    .expire   (expire)
  );

  always_comb begin
    set_v            = '0;
    clr_v            = '0;
    en_v             = '0;
    set_v[SRC_TIMER] = expire;
    set_v[SRC_DMA]   = dma_done;
    clr_v[SRC_TIMER] = evt.ack_timer;
    clr_v[SRC_DMA]   = evt.ack_dma;
    en_v[SRC_TIMER]  = ctl[CTL_TIMER_EN];
    en_v[SRC_DMA]    = ctl[CTL_DMA_EN];
  end

  ost_irq_combine u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (set_v),
    .clr   (clr_v),
    .en    (en_v),
    .flags (flags),
    .irq   (irq)
  );
endmodule

// File: rtl/ost_chk.sv
`timescale 1ns/1ps
module ost_chk (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic dma_done,
  input logic load,
  input logic expire,
  input logic running,
  input logic tflag,
  input logic dflag,
  input logic ack_t,
  input logic ack_d,
  input logic ten,
  input logic den
);
  // R1
  load_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> running);

  // R3
  expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!running && tflag));

  // R4
  dma_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> dflag);

  // R7
  tack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_t && !expire) |=> !tflag);

  // R7
  dack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_d && !dma_done) |=> !dflag);

  // R6
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tflag && ten) || (dflag && den)) |=> irq);
endmodule

bind oneshot_irq_timer ost_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq      (irq),
  .dma_done (dma_done),
  .load     (evt.load),
  .expire   (expire),
  .running  (running),
  .tflag    (flags[0]),
  .dflag    (flags[1]),
  .ack_t    (evt.ack_timer),
  .ack_d    (evt.ack_dma),
  .ten      (ctl[1]),
  .den      (ctl[2])
);

// File: tb/sim_oneshot_irq_timer.sv
`timescale 1ns/1ps
module sim_oneshot_irq_timer;
  localparam int AW   = 6;
  localparam int FL   = 2;
  localparam int SL   = 4;
  localparam int FAST = 1 << FL;
  localparam int SLOW = 1 << SL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cpu_ce = 1'b1;
  logic          bus_sel = 1'b0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [7:0]    bus_wdata = '0;
  logic [7:0]    bus_rdata;
  logic          dma_done = 1'b0;
  logic          irq;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  gate = 1'b0;
  bit  done = 1'b0;

  // reference model state
  int       m_rem = 0;
  bit       m_run = 0;
  bit       m_tf = 0;
  bit       m_df = 0;
  bit       m_irq = 0;
  bit [7:0] m_ctl = 0;

  always #4 clk = ~clk;

  oneshot_irq_timer #(.ADDR_W(AW), .FAST_LOG2(FL), .SLOW_LOG2(SL)) u0 (
    .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .bus_sel(bus_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .dma_done(dma_done), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // model update at each edge
  always @(posedge clk) begin
    bit exp_t;
    bit ld, ackt, ackd;
    if (!rst_n) begin
      m_rem = 0; m_run = 0; m_tf = 0; m_df = 0; m_irq = 0; m_ctl = 0;
    end else begin
      exp_t = 0;
      ld   = bus_sel && bus_we && bus_addr == 6'h23;
      ackt = bus_sel && !bus_we && bus_addr == 6'h24;
      ackd = bus_sel && !bus_we && bus_addr == 6'h25;
      if (ld) begin
        m_run = 1;
        m_rem = ((bus_wdata == 0) ? 256 : int'(bus_wdata)) * (m_ctl[4] ? SLOW : FAST);
      end else if (m_run && cpu_ce) begin
        m_rem--;
        if (m_rem == 0) begin m_run = 0; exp_t = 1; end
      end
      m_irq = (m_tf && m_ctl[1]) || (m_df && m_ctl[2]);
      m_tf = exp_t ? 1'b1 : (ackt ? 1'b0 : m_tf);
      m_df = dma_done ? 1'b1 : (ackd ? 1'b0 : m_df);
      if (bus_sel && bus_we && bus_addr == 6'h26) m_ctl = bus_wdata;
    end
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    logic [7:0] exp_rd;
    if (rst_n && !done) begin
      exp_rd = 8'h00;
      if (bus_sel && !bus_we && bus_addr == 6'h27) exp_rd = {6'b0, m_df, m_tf};
      else if (bus_sel && !bus_we && bus_addr == 6'h26) exp_rd = m_ctl;
      check(irq === m_irq, "R6 irq vs model", int'(irq), int'(m_irq));
      check(bus_rdata === exp_rd, "R5 rdata vs model", int'(bus_rdata), int'(exp_rd));
    end
  end

  always @(negedge clk) begin
    #1;
    cpu_ce <= gate ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_sel = 1; bus_we = 1; bus_addr = a[AW-1:0]; bus_wdata = d;
    @(negedge clk); #1;
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    bus_sel = 1; bus_we = 0; bus_addr = a[AW-1:0];
    @(negedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic stat(input logic [7:0] exp, input string req);
    bus_sel = 1; bus_we = 0; bus_addr = 6'h27;
    @(negedge clk);
    check(bus_rdata === exp, req, int'(bus_rdata), int'(exp));
    #1;
    bus_sel = 0;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    @(negedge clk);
    check(irq === 1'b0, "R8 irq low in reset", int'(irq), 0);
    #1 rst_n = 1;
    idle(1);
    stat(8'h00, "R8 flags clear after reset");
    bus_sel = 1; bus_we = 0; bus_addr = 6'h26;
    @(negedge clk);
    check(bus_rdata === 8'h00, "R8 control clear after reset", int'(bus_rdata), 0);
    #1 bus_sel = 0;

    // fast prescale, count 3 -> 12 cycles
    wr(8'h26, 8'h02);
    wr(8'h23, 8'd3);
    idle(10);
    stat(8'h00, "R2 fast: no flag one cycle early");
    stat(8'h01, "R2 fast: flag at count x prescale");
    idle(1);
    check(irq === 1'b1, "R6 irq after enabled timer flag", int'(irq), 1);
    rd(8'h24);
    stat(8'h00, "R7 timer ack clears flag");
    check(irq === 1'b0, "R7 irq falls after ack", int'(irq), 0);

    // count 0 means 256
    wr(8'h26, 8'h00);
    wr(8'h23, 8'h00);
    idle(256 * FAST - 2);
    stat(8'h00, "R1 zero count not yet expired");
    stat(8'h01, "R1 zero count expires at 256 steps");
    check(irq === 1'b0, "R6 masked timer flag keeps irq low", int'(irq), 0);
    rd(8'h24);

    // slow prescale, count 2
    wr(8'h26, 8'h10);
    wr(8'h23, 8'd2);
    idle(2 * SLOW - 2);
    stat(8'h00, "R2 slow: no flag one cycle early");
    stat(8'h01, "R2 slow: flag at count x slow prescale");
    rd(8'h24);

    // restart while running
    wr(8'h26, 8'h02);
    wr(8'h23, 8'd5);
    idle(10);
    wr(8'h23, 8'd1);
    idle(2);
    stat(8'h00, "R9 restarted: not yet");
    stat(8'h01, "R9 restarted: new period");
    idle(40);
    stat(8'h01, "R3 flag sticky without ack");
    rd(8'h24);
    idle(200);
    stat(8'h00, "R3 no re-fire after expiry");

    // dma flag, masked then enabled
    wr(8'h26, 8'h00);
    dma_done = 1; idle(1); dma_done = 0;
    idle(3);
    check(irq === 1'b0, "R4 masked dma keeps irq low", int'(irq), 0);
    stat(8'h02, "R4 dma flag sticky");
    wr(8'h26, 8'h04);
    idle(1);
    check(irq === 1'b1, "R10 control write raises irq", int'(irq), 1);
    rd(8'h25);
    idle(1);
    check(irq === 1'b0, "R7 dma ack drops irq", int'(irq), 0);
    stat(8'h00, "R7 dma flag cleared");

    // set and ack together
    dma_done = 1; bus_sel = 1; bus_we = 0; bus_addr = 6'h25;
    idle(1);
    dma_done = 0; bus_sel = 0;
    stat(8'h02, "R4 set wins over ack");
    rd(8'h25);
    wr(8'h26, 8'h00);
    idle(1);
    check(irq === 1'b0, "R10 control write drops irq", int'(irq), 0);

    // gated cpu enable, model-compared
    wr(8'h26, 8'h06);
    gate = 1;
    wr(8'h23, 8'd2);
    idle(40);
    dma_done = 1; idle(1); dma_done = 0;
    idle(30);
    gate = 0;
    idle(5);
    stat({6'b0, 1'b1, 1'b1}, "R2 gated enable eventually expires");
    rd(8'h24);
    rd(8'h25);
    idle(3);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule